// File: doc/BRIEF.md
# Serial Flash SPI Host Controller

This block is a single-device SPI host aimed at serial flash parts. Software drives it through a small 32-bit register window: a command word, a status word, a transmit queue port and a receive queue port. Software pushes one data word of 1 to 32 bits into the transmit queue and writes the command word with its start bit set. The controller then shifts the active low bits of that word out on MOSI, most significant first. In the same clocks it gathers the same number of bits from MISO into one receive word and pushes that word into the receive queue.

Chip select can follow the transfer engine, which holds it low while a word is shifting. It can also be held by software across any number of single-word transfers. The serial clock is the system clock divided by an even parameter. The idle clock level and the sampling edge are set in the command word.

Inside the block the two queues are valid/ready streams. A push is accepted only while the queue has space, and a pop only while it holds data. At the register window, back-pressure turns into flags: a write to a full transmit queue is dropped and raises a sticky overflow flag. A read of an empty receive queue returns zero and raises a sticky underrun flag.

Top module: `flash_spi_host`

## Requirements
- R1: After reset the status word at byte offset 0x04 reads 0x0280_0000 (bit 25 receive-empty and bit 23 transmit-empty set, all else clear), spi_cs_n is high and spi_sck is low.
- R2: Command bits 4:0 hold the bit count minus one (n = field + 1). A command write with bit 30 set shifts bits n-1..0 of the transmit queue head out on MOSI, highest bit first. Engine busy lasts exactly 2·n·(SCK_DIV/2) system cycles and begins one cycle after the command write.
- R3: The n received bits land in bits n-1..0 of one word, the first received bit highest and the upper bits zero. The word is pushed into the receive queue and read at byte offset 0x20.
- R4: Command bit 30 reads back 1 while a start is pending and 0 once shifting begins. With transmit enabled and the transmit queue empty, a pending start waits until a word is written to offset 0x10.
- R5: Status bit 30 (ready) sets when a word completes and stays set until a 1 is written to it. Writing back a status value just read clears every sticky flag that value showed.
- R6: A write to offset 0x10 while the transmit queue is full is dropped and sets sticky status bit 26. Status bit 22 shows the transmit queue full. Writing 1 to bit 26 clears the flag.
- R7: A read of offset 0x20 with the receive queue empty returns 0 and sets sticky status bit 27. Writing 1 to bit 27 clears the flag.
- R8: Writing 1 to status bit 28 empties the transmit queue and writing 1 to bit 29 empties the receive queue. Both bits read back 0.
- R9: With command bit 12 set, spi_cs_n is the inverse of command bit 13. With bit 12 clear, spi_cs_n is low exactly while the engine is busy.
- R10: Command bit 26 sets the idle level of spi_sck. Command bit 18 clear samples on the leading edge, and set samples on the trailing edge. In every one of the four combinations a looped-back word returns unchanged.
- R11: With command bit 15 (transmit enable) clear, MOSI shifts zeros and the transmit queue is not popped. With command bit 14 (receive enable) clear, no word is pushed into the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe; a read of 0x20 pops the receive queue |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A start written at clock edge E begins shifting at edge E+1. Busy, and in hardware select mode the low chip select, then lasts exactly 2·n·(SCK_DIV/2) cycles. The bench counts low chip-select cycles at falling edges and compares the count with that figure. The ready flag and the receive word follow one edge after busy ends, so the bench waits two further cycles before reading status or the receive port. Register reads are combinational and are sampled in the low half of the cycle before the popping edge, and pin levels after a command write are sampled at the next falling edge.

// File: rtl/flash_spi_pkg.sv
package flash_spi_pkg;
  localparam int REG_W = 32;
  localparam int LEN_W = 5;
  localparam int AW    = 6;

  localparam logic [AW-1:0] OFS_CMD  = 6'h00;
  localparam logic [AW-1:0] OFS_STAT = 6'h04;
  localparam logic [AW-1:0] OFS_TXQ  = 6'h10;
  localparam logic [AW-1:0] OFS_RXQ  = 6'h20;

  // command word bit positions
  localparam int C_GO    = 30;
  localparam int C_CPOL  = 26;
  localparam int C_CPHA  = 18;
  localparam int C_TXEN  = 15;
  localparam int C_RXEN  = 14;
  localparam int C_CSVAL = 13;
  localparam int C_CSSW  = 12;

  // status word bit positions
  localparam int S_BUSY  = 31;
  localparam int S_RDY   = 30;
  localparam int S_RXFL  = 29;
  localparam int S_TXFL  = 28;
  localparam int S_UNR   = 27;
  localparam int S_OVF   = 26;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic             cpol;
    logic             cpha;
    logic             tx_en;
    logic             rx_en;
  } xfer_cfg_t;
endpackage

// File: rtl/fsh_fifo.sv
module fsh_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             push, pop;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= in_data;
  end
endmodule

// File: rtl/fsh_shift_engine.sv
module fsh_shift_engine
  import flash_spi_pkg::*;
#(
  parameter int SCK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  xfer_cfg_t        cfg,
  input  logic [REG_W-1:0] tx_word,
  output logic             busy,
  output logic             done,
  output logic [REG_W-1:0] rx_word,
  output logic             rx_keep,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  localparam int HALF = (SCK_DIV < 2) ? 1 : SCK_DIV / 2;
  localparam int HCW  = $clog2(HALF + 1);
  localparam int ECW  = LEN_W + 2;

  logic [HCW-1:0]   hc;
  logic [ECW-1:0]   edges, taken, last_edge;
  logic [REG_W-1:0] sh_out, sh_in;
  logic             cpha_q, rxen_q;
  logic             tick, leading, sample_now;

  assign tick       = busy && (hc == HCW'(HALF - 1));
  assign leading    = ~edges[0];
  assign sample_now = leading ^ cpha_q;
  assign mosi       = sh_out[REG_W-1];
  assign rx_word    = sh_in;
  assign rx_keep    = rxen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      hc        <= '0;
      edges     <= '0;
      taken     <= '0;
      last_edge <= '0;
      sh_out    <= '0;
      sh_in     <= '0;
      sck       <= 1'b0;
      cpha_q    <= 1'b0;
      rxen_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck <= cfg.cpol;
        if (start) begin
          busy      <= 1'b1;
          hc        <= '0;
          edges     <= '0;
          taken     <= '0;
          last_edge <= ECW'({cfg.len_m1, 1'b1});
          sh_out    <= cfg.tx_en ? (tx_word << (LEN_W'(REG_W - 1) - cfg.len_m1)) : '0;
          sh_in     <= '0;
          cpha_q    <= cfg.cpha;
          rxen_q    <= cfg.rx_en;
        end
      end else if (tick) begin
        hc    <= '0;
        sck   <= ~sck;
        edges <= edges + 1'b1;
        if (sample_now) begin
          sh_in <= {sh_in[REG_W-2:0], miso};
          taken <= taken + 1'b1;
        end else if (taken != '0) begin
          sh_out <= sh_out << 1;
        end
        if (edges == last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsh_regs.sv
module fsh_regs
  import flash_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic             tx_space,
  input  logic             tx_avail,
  input  logic             rx_space,
  input  logic             rx_avail,
  input  logic [REG_W-1:0] rx_head,
  output xfer_cfg_t        cfg,
  output logic             start,
  output logic             go_pend,
  output logic             rdy,
  output logic             cs_soft,
  output logic             cs_val,
  output logic             tx_push,
  output logic             rx_pop,
  output logic             tx_flush,
  output logic             rx_flush
);
  logic [REG_W-1:0] cmd_q;
  logic             go_q, rdy_q, ovf_q, unr_q;
  logic             wr_cmd, wr_stat, wr_tx, rd_rx;

  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_tx   = bus_wr && (bus_addr == OFS_TXQ);
  assign rd_rx   = bus_rd && (bus_addr == OFS_RXQ);

  always_comb begin
    cfg.len_m1 = cmd_q[LEN_W-1:0];
    cfg.cpol   = cmd_q[C_CPOL];
    cfg.cpha   = cmd_q[C_CPHA];
    cfg.tx_en  = cmd_q[C_TXEN];
    cfg.rx_en  = cmd_q[C_RXEN];
  end

  assign start    = go_q && !busy && (!cmd_q[C_TXEN] || tx_avail);
  assign go_pend  = go_q;
  assign rdy      = rdy_q;
  assign cs_soft  = cmd_q[C_CSSW];
  assign cs_val   = cmd_q[C_CSVAL];
  assign tx_push  = wr_tx;
  assign rx_pop   = rd_rx;
  assign tx_flush = wr_stat && bus_wdata[S_TXFL];
  assign rx_flush = wr_stat && bus_wdata[S_RXFL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      go_q  <= 1'b0;
      rdy_q <= 1'b0;
      ovf_q <= 1'b0;
      unr_q <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= bus_wdata & ~(REG_W'(1) << C_GO);
      go_q  <= (go_q && !start) || (wr_cmd && bus_wdata[C_GO]);
      rdy_q <= (rdy_q && !(wr_stat && bus_wdata[S_RDY])) || done;
      ovf_q <= (ovf_q && !(wr_stat && bus_wdata[S_OVF])) || (wr_tx && !tx_space);
      unr_q <= (unr_q && !(wr_stat && bus_wdata[S_UNR])) || (rd_rx && !rx_avail);
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CMD:  bus_rdata = cmd_q | (REG_W'(go_q) << C_GO);
      OFS_STAT: bus_rdata = {busy, rdy_q, 1'b0, 1'b0, unr_q, ovf_q,
                             !rx_avail, !rx_space, !tx_avail, !tx_space, 22'd0};
      OFS_RXQ:  bus_rdata = rx_avail ? rx_head : '0;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_spi_host.sv
module flash_spi_host
  import flash_spi_pkg::*;
#(
  parameter int SCK_DIV    = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  xfer_cfg_t        cfg;
  logic             start, go_pend, rdy_flag, cs_soft, cs_val;
  logic             tx_push, rx_pop, tx_flush, rx_flush;
  logic             tx_space, tx_avail, rx_space, rx_avail;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             eng_busy, eng_done, eng_rx_keep;
  logic [REG_W-1:0] tx_head, rx_head, eng_rx_word;

  assign tx_full  = !tx_space;
  assign tx_empty = !tx_avail;
  assign rx_full  = !rx_space;
  assign rx_empty = !rx_avail;
  assign spi_cs_n = cs_soft ? ~cs_val : ~eng_busy;

  fsh_regs u_regs (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .busy(eng_busy), .done(eng_done),
    .tx_space, .tx_avail, .rx_space, .rx_avail, .rx_head,
    .cfg, .start, .go_pend, .rdy(rdy_flag), .cs_soft, .cs_val,
    .tx_push, .rx_pop, .tx_flush, .rx_flush
  );

  fsh_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .flush(tx_flush),
    .in_valid(tx_push), .in_ready(tx_space), .in_data(bus_wdata),
    .out_valid(tx_avail), .out_ready(start && cfg.tx_en), .out_data(tx_head)
  );

  fsh_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .flush(rx_flush),
    .in_valid(eng_done && eng_rx_keep), .in_ready(rx_space), .in_data(eng_rx_word),
    .out_valid(rx_avail), .out_ready(rx_pop), .out_data(rx_head)
  );

  fsh_shift_engine #(.SCK_DIV(SCK_DIV)) u_eng (
    .clk, .rst_n, .start, .cfg, .tx_word(tx_head),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx_word), .rx_keep(eng_rx_keep),
    .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/flash_spi_host_chk.sv
module flash_spi_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic go_pend,
  input logic rdy,
  input logic sck,
  input logic cpol,
  input logic tx_full,
  input logic tx_empty,
  input logic rx_full,
  input logic rx_empty
);
  AST_START_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go_pend)) else $error("start without pending go"); // R4
  AST_RDY_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> rdy) else $error("ready missing after word"); // R5
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sck == $past(cpol))) else $error("sck off idle level"); // R10
  AST_TXQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty)) else $error("tx queue full and empty"); // R6
  AST_RXQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty)) else $error("rx queue full and empty"); // R7
endmodule

bind flash_spi_host flash_spi_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .go_pend(go_pend), .rdy(rdy_flag),
  .sck(spi_sck), .cpol(cfg.cpol), .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_full(rx_full), .rx_empty(rx_empty)
);

// File: tb/flash_spi_host_test.sv
module flash_spi_host_test;
  localparam int SCK_DIV = 4;
  localparam int HALF    = SCK_DIV / 2;
  localparam int DEPTH   = 4;
  localparam logic [5:0] A_CMD = 6'h00, A_STAT = 6'h04, A_TXQ = 6'h10, A_RXQ = 6'h20;
  localparam logic [31:0] GO = 32'h4000_0000, TXEN = 32'h0000_8000, RXEN = 32'h0000_4000;
  localparam logic [31:0] ST_IDLE = 32'h0280_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso;

  int total = 0;
  int bad   = 0;

  logic        mon_en = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
  logic [31:0] mon_bits = '0;
  int          mon_cnt = 0;

  assign spi_miso = spi_mosi;   // loopback slave

  flash_spi_host #(.SCK_DIV(SCK_DIV), .FIFO_DEPTH(DEPTH)) uut (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .spi_sck, .spi_mosi, .spi_miso, .spi_cs_n
  );

  always #10 clk = ~clk;

  // records MOSI at every edge on which a slave samples
  always @(spi_sck) begin
    if (mon_en && ((spi_sck != mon_cpol) ^ mon_cpha)) begin
      mon_bits = {mon_bits[30:0], spi_mosi};
      mon_cnt  = mon_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic count_cs_low(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!spi_cs_n) n++;
      else if (n > 0) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(A_STAT, v);
    check(v == ST_IDLE, "R1 status after reset", v, ST_IDLE);
    check(spi_cs_n == 1'b1, "R1 cs_n after reset", 32'(spi_cs_n), 32'd1);
    check(spi_sck == 1'b0, "R1 sck after reset", 32'(spi_sck), 32'd0);
  endtask

  task automatic t_xfer(input int len, input logic [31:0] word, input logic cpol, input logic cpha);
    logic [31:0] base, v, mask, expw;
    int n, low;
    n    = len + 1;
    mask = 32'(((64'd1) << n) - 64'd1);
    expw = word & mask;
    base = TXEN | RXEN | (32'(cpol) << 26) | (32'(cpha) << 18) | 32'(len);
    bus_write(A_CMD, base);
    repeat (2) @(negedge clk);
    mon_cpol = cpol; mon_cpha = cpha; mon_bits = '0; mon_cnt = 0; mon_en = 1'b1;
    bus_write(A_TXQ, word);
    bus_write(A_CMD, base | GO);
    count_cs_low(low);
    mon_en = 1'b0;
    check(low == 2 * n * HALF, "R2 busy length", 32'(low), 32'(2 * n * HALF));
    check(mon_cnt == n, "R2 bit count", 32'(mon_cnt), 32'(n));
    check(mon_bits == expw, "R2 MSB-first MOSI", mon_bits, expw);
    check(spi_sck == cpol, "R10 idle sck level", 32'(spi_sck), 32'(cpol));
    repeat (2) @(negedge clk);
    bus_read(A_STAT, v);
    check(v == 32'h4080_0000, "R5 ready after word", v, 32'h4080_0000);
    bus_read(A_RXQ, v);
    check(v == expw, "R3 R10 loopback word", v, expw);
    bus_read(A_STAT, v);
    bus_write(A_STAT, v);
    bus_read(A_STAT, v);
    check(v == ST_IDLE, "R5 write-back clears", v, ST_IDLE);
  endtask

  task automatic t_go_wait();
    logic [31:0] base, v;
    int low;
    base = TXEN | RXEN | 32'd7;
    bus_write(A_CMD, base | GO);
    bus_read(A_CMD, v);
    check(v[30] == 1'b1, "R4 go pending reads 1", v, base | GO);
    repeat (10) @(negedge clk);
    check(spi_cs_n == 1'b1, "R4 waits for data", 32'(spi_cs_n), 32'd1);
    bus_write(A_TXQ, 32'h0000_00A5);
    count_cs_low(low);
    check(low == 2 * 8 * HALF, "R4 R9 runs once data arrives", 32'(low), 32'(2 * 8 * HALF));
    bus_read(A_CMD, v);
    check(v[30] == 1'b0, "R4 go self-clears", v, base);
    repeat (2) @(negedge clk);
    bus_read(A_RXQ, v);
    check(v == 32'h0000_00A5, "R3 rx word", v, 32'h0000_00A5);
    bus_write(A_STAT, 32'h4000_0000);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    bus_write(A_CMD, TXEN | RXEN | 32'd7);
    for (int i = 0; i <= DEPTH; i++) bus_write(A_TXQ, 32'(i));
    bus_read(A_STAT, v);
    check(v == 32'h0640_0000, "R6 full and overflow", v, 32'h0640_0000);
    bus_write(A_STAT, 32'h0400_0000);
    bus_read(A_STAT, v);
    check(v == 32'h0240_0000, "R6 overflow cleared", v, 32'h0240_0000);
    bus_write(A_STAT, 32'h1000_0000);
    bus_read(A_STAT, v);
    check(v == ST_IDLE, "R8 tx flush", v, ST_IDLE);
  endtask

  task automatic t_underrun();
    logic [31:0] v;
    bus_read(A_RXQ, v);
    check(v == 32'd0, "R7 empty read returns 0", v, 32'd0);
    bus_read(A_STAT, v);
    check(v == 32'h0A80_0000, "R7 underrun flag", v, 32'h0A80_0000);
    bus_write(A_STAT, 32'h0800_0000);
    bus_read(A_STAT, v);
    check(v == ST_IDLE, "R7 underrun cleared", v, ST_IDLE);
  endtask

  task automatic t_rx_flush();
    logic [31:0] v;
    int low;
    bus_write(A_TXQ, 32'h0000_3C);
    bus_write(A_CMD, TXEN | RXEN | GO | 32'd7);
    count_cs_low(low);
    repeat (2) @(negedge clk);
    bus_write(A_STAT, 32'h6000_0000);
    bus_read(A_STAT, v);
    check(v == ST_IDLE, "R8 rx flush", v, ST_IDLE);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    int low;
    bus_write(A_TXQ, 32'h0000_1234);
    bus_write(A_CMD, 32'd15);
    repeat (2) @(negedge clk);
    mon_cpol = 1'b0; mon_cpha = 1'b0; mon_bits = 32'hFFFF_FFFF; mon_cnt = 0; mon_en = 1'b1;
    bus_write(A_CMD, GO | 32'd15);
    count_cs_low(low);
    mon_en = 1'b0;
    check(mon_cnt == 16 && mon_bits[15:0] == 16'd0, "R11 MOSI zero without tx enable", mon_bits, 32'hFFFF_0000);
    repeat (2) @(negedge clk);
    bus_read(A_STAT, v);
    check(v == 32'h4200_0000, "R11 tx kept, rx not pushed", v, 32'h4200_0000);
    bus_write(A_STAT, 32'h5000_0000);
    bus_write(A_CMD, RXEN | GO | 32'd7);
    count_cs_low(low);
    repeat (2) @(negedge clk);
    bus_read(A_RXQ, v);
    check(v == 32'd0, "R11 zero word received", v, 32'd0);
    bus_write(A_STAT, 32'h4000_0000);
  endtask

  task automatic t_soft_cs();
    int low;
    bus_write(A_CMD, 32'h0000_3000);
    check(spi_cs_n == 1'b0, "R9 soft select low", 32'(spi_cs_n), 32'd0);
    bus_write(A_TXQ, 32'h0000_0055);
    bus_write(A_CMD, 32'h0000_3000 | TXEN | GO | 32'd7);
    repeat (60) @(negedge clk);
    check(spi_cs_n == 1'b0, "R9 held across word", 32'(spi_cs_n), 32'd0);
    bus_write(A_CMD, 32'h0000_1000);
    check(spi_cs_n == 1'b1, "R9 soft select high", 32'(spi_cs_n), 32'd1);
    bus_write(A_STAT, 32'h4000_0000);
    bus_write(A_CMD, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xfer(7,  32'h0000_00C3, 1'b0, 1'b0);
    t_xfer(15, 32'h0000_8E21, 1'b0, 1'b1);
    t_xfer(31, 32'hB1E0_4D27, 1'b1, 1'b0);
    t_xfer(23, 32'h00F0_0A81, 1'b1, 1'b1);
    t_xfer(0,  32'h0000_0001, 1'b0, 1'b0);
    t_go_wait();
    t_overflow();
    t_underrun();
    t_rx_flush();
    t_enables();
    t_soft_cs();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule